// File: doc/BRIEF.md
# Two-Operand Byte ALU with Shift, Rotate and Multiply

This unit performs the data operation of a small two-address CISC processor. Each cycle it takes a 4-bit operation code, the destination operand (which is also the first input), the source operand and the current carry flag. It computes a byte result and new zero, negative, overflow and carry flags. The sixteen operations are the add and subtract family (plain and with carry), move, three bitwise operations, three shifts, a plain rotate, a rotate through carry and three multiply variants.

The immediate instruction forms use the same operation code in the upper nibble of their first byte, with the immediate byte in place of a register. The surrounding core places that byte on the source input, so the unit handles immediate forms with no change. The result and flags are registered once, so they appear one clock after the operands. Register access, operand fetch and write-back are done by the core around it.

Top module: `alu8_core`

## Requirements
- R1: Code 0x0 (add) returns (dst + src) mod 256, C is the carry out of bit 7, V is set on signed overflow.
- R2: Code 0x1 (sub) returns (dst - src) mod 256, C is 1 when no borrow occurs (dst >= src unsigned), V is set on signed overflow.
- R3: Code 0x2 (add with carry) returns dst + src + C. Code 0x3 (subtract with borrow) returns dst - src - (1 - C), with C again meaning "no borrow". V is set on signed overflow for both.
- R4: Code 0x4 (move) returns src, clears V and keeps the incoming C.
- R5: Codes 0x5 (xor), 0x6 (or) and 0x7 (and) return the bitwise result, clear V and keep C.
- R6: Codes 0x8 (shift left), 0x9 (arithmetic shift right) and 0xA (logical shift right) shift dst by n = src[2:0]. C takes the last bit shifted out and V is cleared.
- R7: Code 0xB rotates dst left by n = src[2:0] inside 8 bits, keeps C and clears V.
- R8: Code 0xF rotates the 9-bit value {C, dst} left by n = src[2:0]. The result is (C << (n-1)) | (dst << n) | (dst >> (9-n)) and the new C is dst bit (8-n). V is cleared.
- R9: For codes 0x8, 0x9, 0xA, 0xB and 0xF, src bits 7..3 have no effect. A count of 0 returns dst and keeps C.
- R10: Code 0xC returns the low byte of dst*src. Code 0xD returns the high byte of the unsigned product. Code 0xE returns the high byte of the two's-complement signed product. All three clear V and keep C.
- R11: For every operation Z is 1 exactly when the result is 0, and N equals result bit 7.
- R12: Result and flags are registered and change one clock after the inputs. While rst_n is low they are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation code |
| dst_i | input | 8 | Destination operand |
| src_i | input | 8 | Source operand or immediate byte |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 8 | Registered result |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
On every cycle the assertions check the registered add sum with its carry, the move pass-through, that carry is kept and overflow cleared by the logic and multiply codes, the low multiply byte, and the count-zero behaviour of the shift codes. The high multiply bytes, the overflow rules of the subtract family, the exact bit placement of the rotate through carry and the reset value are shown only by the bench. It compares every cycle against a behavioural model, using directed corner operands and then a long run of random ones.

// File: rtl/alu8_pkg.sv
// Package alu8_pkg: shared widths and the operation code set of the byte ALU.
// Assumes the operation code is always 4 bits wide.
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_ADDC = 4'h2,
        OP_SUBB = 4'h3,
        OP_MOV  = 4'h4,
        OP_XOR  = 4'h5,
        OP_OR   = 4'h6,
        OP_AND  = 4'h7,
        OP_LSL  = 4'h8,
        OP_ASR  = 4'h9,
        OP_SHR  = 4'hA,
        OP_ROT  = 4'hB,
        OP_MUL  = 4'hC,
        OP_MUH  = 4'hD,
        OP_MUS  = 4'hE,
        OP_ROTC = 4'hF
    } alu_op_e;

endpackage

// File: rtl/alu8_addsub.sv
// Module alu8_addsub: one adder serving add, subtract and their carry forms.
// sel_i[0] selects subtraction (operand inverted), sel_i[1] uses the carry in.
// Carry out for subtraction is the no-borrow convention. Purely combinational.
module alu8_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [1:0]       sel_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             ovf_o
);

    logic [WIDTH-1:0] b_eff;
    logic             cin;
    logic [WIDTH:0]   wide;

    // Pick the second operand and the carry in for the selected form.
    always_comb begin
        b_eff = sel_i[0] ? ~b_i : b_i;
        if (sel_i[1])
            cin = carry_i;
        else
            cin = sel_i[0];
        wide    = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
        sum_o   = wide[WIDTH-1:0];
        carry_o = wide[WIDTH];
        ovf_o   = (a_i[WIDTH-1] == b_eff[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]);
    end

endmodule

// File: rtl/alu8_shifter.sv
// Module alu8_shifter: variable-count shifts and rotates of one operand.
// kind_i is the low three bits of the operation code: 000 shift left,
// 001 arithmetic right, 010 logical right, 011 rotate, 111 rotate through
// carry. A count of zero returns the operand and the incoming carry.
module alu8_shifter #(
    parameter int WIDTH = 8,
    localparam int CNT_W = $clog2(WIDTH)
) (
    input  logic [2:0]       kind_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] res_o,
    output logic             carry_o
);

    logic [WIDTH:0]        left_ext;
    logic [WIDTH:0]        right_log;
    logic signed [WIDTH:0] right_ar;
    logic [WIDTH-1:0]      rot_plain;
    logic [WIDTH:0]        rot_ext;
    logic [WIDTH:0]        ring;

    // Shift variants carry one guard bit that holds the last bit shifted out.
    always_comb begin
        left_ext  = {1'b0, data_i} << count_i;
        right_log = {data_i, 1'b0} >> count_i;
        right_ar  = $signed({data_i, 1'b0}) >>> count_i;
    end

    // Rotates pick each output bit from its source position modulo the ring.
    always_comb begin
        ring = {carry_i, data_i};
        for (int i = 0; i < WIDTH; i++)
            rot_plain[i] = data_i[(i + WIDTH - int'(count_i)) % WIDTH];
        for (int i = 0; i <= WIDTH; i++)
            rot_ext[i] = ring[(i + WIDTH + 1 - int'(count_i)) % (WIDTH + 1)];
    end

    // Select the variant; count zero leaves operand and carry alone.
    always_comb begin
        res_o   = data_i;
        carry_o = carry_i;
        if (count_i != '0) begin
            unique case (kind_i)
                3'b000: begin
                    res_o   = left_ext[WIDTH-1:0];
                    carry_o = left_ext[WIDTH];
                end
                3'b001: begin
                    res_o   = right_ar[WIDTH:1];
                    carry_o = right_ar[0];
                end
                3'b010: begin
                    res_o   = right_log[WIDTH:1];
                    carry_o = right_log[0];
                end
                3'b011: begin
                    res_o   = rot_plain;
                    carry_o = carry_i;
                end
                3'b111: begin
                    res_o   = rot_ext[WIDTH-1:0];
                    carry_o = rot_ext[WIDTH];
                end
                default: begin
                    res_o   = data_i;
                    carry_o = carry_i;
                end
            endcase
        end
    end

endmodule

// File: rtl/alu8_mult.sv
// Module alu8_mult: one unsigned multiplier giving the low byte, the unsigned
// high byte and the signed high byte. The signed high byte is derived from the
// unsigned product by subtracting the operand corrections. Combinational.
module alu8_mult #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] lo_o,
    output logic [WIDTH-1:0] hi_u_o,
    output logic [WIDTH-1:0] hi_s_o
);

    logic [2*WIDTH-1:0] prod;
    logic [WIDTH-1:0]   fix_a;
    logic [WIDTH-1:0]   fix_b;

    // Unsigned product, then the two's-complement correction of its high half.
    always_comb begin
        prod   = {{WIDTH{1'b0}}, a_i} * {{WIDTH{1'b0}}, b_i};
        lo_o   = prod[WIDTH-1:0];
        hi_u_o = prod[2*WIDTH-1:WIDTH];
        fix_a  = a_i[WIDTH-1] ? b_i : '0;
        fix_b  = b_i[WIDTH-1] ? a_i : '0;
        hi_s_o = hi_u_o - fix_a - fix_b;
    end

endmodule

// File: rtl/alu8_core.sv
// Module alu8_core: byte ALU top. Decodes the operation code, selects among the
// adder, shifter, multiplier and logic results, derives the flags and registers
// result and flags for one clock. Assumes operands are stable around the edge.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] dst_i,
    input  logic [WIDTH-1:0] src_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             flag_z_o,
    output logic             flag_n_o,
    output logic             flag_v_o,
    output logic             flag_c_o
);

    localparam int CNT_W = $clog2(WIDTH);

    alu_op_e          op;
    logic [WIDTH-1:0] as_sum;
    logic             as_c;
    logic             as_v;
    logic [WIDTH-1:0] sh_res;
    logic             sh_c;
    logic [WIDTH-1:0] mu_lo;
    logic [WIDTH-1:0] mu_hi_u;
    logic [WIDTH-1:0] mu_hi_s;
    logic [WIDTH-1:0] nxt_res;
    logic             nxt_v;
    logic             nxt_c;

    assign op = alu_op_e'(op_i);

    alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
        .sel_i   (op_i[1:0]),
        .a_i     (dst_i),
        .b_i     (src_i),
        .carry_i (carry_i),
        .sum_o   (as_sum),
        .carry_o (as_c),
        .ovf_o   (as_v)
    );

    alu8_shifter #(.WIDTH(WIDTH)) u_shift (
        .kind_i  (op_i[2:0]),
        .count_i (src_i[CNT_W-1:0]),
        .data_i  (dst_i),
        .carry_i (carry_i),
        .res_o   (sh_res),
        .carry_o (sh_c)
    );

    alu8_mult #(.WIDTH(WIDTH)) u_mult (
        .a_i    (dst_i),
        .b_i    (src_i),
        .lo_o   (mu_lo),
        .hi_u_o (mu_hi_u),
        .hi_s_o (mu_hi_s)
    );

    // Route the selected unit's result and carry/overflow to the flag stage.
    always_comb begin
        nxt_res = dst_i;
        nxt_v   = 1'b0;
        nxt_c   = carry_i;
        unique case (op)
            OP_ADD, OP_SUB, OP_ADDC, OP_SUBB: begin
                nxt_res = as_sum;
                nxt_v   = as_v;
                nxt_c   = as_c;
            end
            OP_MOV: nxt_res = src_i;
            OP_XOR: nxt_res = dst_i ^ src_i;
            OP_OR:  nxt_res = dst_i | src_i;
            OP_AND: nxt_res = dst_i & src_i;
            OP_LSL, OP_ASR, OP_SHR, OP_ROT, OP_ROTC: begin
                nxt_res = sh_res;
                nxt_c   = sh_c;
            end
            OP_MUL: nxt_res = mu_lo;
            OP_MUH: nxt_res = mu_hi_u;
            OP_MUS: nxt_res = mu_hi_s;
            default: nxt_res = dst_i;
        endcase
    end

    // Output register: result and flags, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            flag_z_o <= 1'b0;
            flag_n_o <= 1'b0;
            flag_v_o <= 1'b0;
            flag_c_o <= 1'b0;
        end else begin
            result_o <= nxt_res;
            flag_z_o <= (nxt_res == '0);
            flag_n_o <= nxt_res[WIDTH-1];
            flag_v_o <= nxt_v;
            flag_c_o <= nxt_c;
        end
    end

endmodule

// File: rtl/alu8_core_chk.sv
// Module alu8_core_chk: property checker for alu8_core, attached by bind.
// Relates registered outputs to the operands seen one clock earlier.
module alu8_core_chk #(
    parameter int WIDTH = 8,
    localparam int CNT_W = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_i,
    input logic [WIDTH-1:0] dst_i,
    input logic [WIDTH-1:0] src_i,
    input logic             carry_i,
    input logic [WIDTH-1:0] result_o,
    input logic             flag_v_o,
    input logic             flag_c_o
);

    logic primed;

    // Marks that the previous edge captured operands outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    a_r1_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i) == 4'h0 |->
        {flag_c_o, result_o} == ({1'b0, $past(dst_i)} + {1'b0, $past(src_i)}));

    a_r4_move_passes_source: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i) == 4'h4 |->
        result_o == $past(src_i) && !flag_v_o && flag_c_o == $past(carry_i));

    a_r5_logic_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        primed && ($past(op_i) == 4'h5 || $past(op_i) == 4'h6 || $past(op_i) == 4'h7) |->
        !flag_v_o && flag_c_o == $past(carry_i));

    a_r10_mult_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i) == 4'hC |->
        result_o == ($past(dst_i) * $past(src_i)) && !flag_v_o && flag_c_o == $past(carry_i));

    a_r10_mult_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        primed && ($past(op_i) == 4'hD || $past(op_i) == 4'hE) |->
        !flag_v_o && flag_c_o == $past(carry_i));

    a_r9_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(src_i[CNT_W-1:0]) == '0 &&
        ($past(op_i) == 4'h8 || $past(op_i) == 4'h9 || $past(op_i) == 4'hA ||
         $past(op_i) == 4'hB || $past(op_i) == 4'hF) |->
        result_o == $past(dst_i) && flag_c_o == $past(carry_i) && !flag_v_o);

endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .dst_i    (dst_i),
    .src_i    (src_i),
    .carry_i  (carry_i),
    .result_o (result_o),
    .flag_v_o (flag_v_o),
    .flag_c_o (flag_c_o)
);

// File: tb/tb_alu8_core.sv
// Bench for alu8_core: behavioural model with integer arithmetic, inputs driven
// on the falling edge, outputs compared on the following falling edge.
module tb_alu8_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] dst_i = '0;
    logic [7:0] src_i = '0;
    logic       carry_i = 1'b0;
    logic [7:0] result_o;
    logic       flag_z_o, flag_n_o, flag_v_o, flag_c_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .dst_i(dst_i), .src_i(src_i),
        .carry_i(carry_i), .result_o(result_o), .flag_z_o(flag_z_o),
        .flag_n_o(flag_n_o), .flag_v_o(flag_v_o), .flag_c_o(flag_c_o)
    );

    // Behavioural reference: returns {result, z, n, v, c}.
    function automatic logic [11:0] model(input int op, input int d, input int s, input int c);
        int r, co, v, t, n, nc, sd, ss, p;
        r = d; co = c; v = 0; n = s & 7;
        case (op)
            0:  begin t = d + s;         r = t & 255; co = (t > 255) ? 1 : 0; v = (((d ^ r) & (s ^ r) & 128) != 0) ? 1 : 0; end
            2:  begin t = d + s + c;     r = t & 255; co = (t > 255) ? 1 : 0; v = (((d ^ r) & (s ^ r) & 128) != 0) ? 1 : 0; end
            1:  begin t = d - s;         r = t & 255; co = (t >= 0) ? 1 : 0;  v = (((d ^ s) & (d ^ r) & 128) != 0) ? 1 : 0; end
            3:  begin t = d - s - (1-c); r = t & 255; co = (t >= 0) ? 1 : 0;  v = (((d ^ s) & (d ^ r) & 128) != 0) ? 1 : 0; end
            4:  r = s;
            5:  r = d ^ s;
            6:  r = d | s;
            7:  r = d & s;
            8:  repeat (n) begin co = (r >> 7) & 1; r = (r << 1) & 255; end
            9:  repeat (n) begin co = r & 1; r = (r >> 1) | (r & 128); end
            10: repeat (n) begin co = r & 1; r = r >> 1; end
            11: repeat (n) r = ((r << 1) | (r >> 7)) & 255;
            12: r = (d * s) & 255;
            13: r = (d * s) >> 8;
            14: begin
                sd = (d >= 128) ? d - 256 : d;
                ss = (s >= 128) ? s - 256 : s;
                p  = sd * ss;
                r  = (p >>> 8) & 255;
            end
            default: repeat (n) begin nc = (r >> 7) & 1; r = ((r << 1) | co) & 255; co = nc; end
        endcase
        model = {r[7:0], (r == 0), r[7], v[0], co[0]};
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0: tag_of = "R1";  1: tag_of = "R2";  2, 3: tag_of = "R3";
            4: tag_of = "R4";  5, 6, 7: tag_of = "R5";  8, 9, 10: tag_of = "R6";
            11: tag_of = "R7"; 12, 13, 14: tag_of = "R10"; default: tag_of = "R8";
        endcase
    endfunction

    task automatic compare(input string tag, input logic [11:0] exp);
        logic [11:0] act;
        act = {result_o, flag_z_o, flag_n_o, flag_v_o, flag_c_o};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual res=%02h znvc=%04b expected res=%02h znvc=%04b",
                     tag, act[11:4], act[3:0], exp[11:4], exp[3:0]);
        end
    endtask

    // Drive one operation, then compare one clock later (R12 latency, R11 flags).
    task automatic apply(input int op, input int d, input int s, input int c, input string tag);
        logic [11:0] exp;
        op_i = 4'(op); dst_i = 8'(d); src_i = 8'(s); carry_i = c[0];
        exp = model(op, d, s, c);
        @(negedge clk);
        compare(tag, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        op_i = 4'h0; dst_i = 8'hFF; src_i = 8'hFF; carry_i = 1'b1;
        @(negedge clk);
        compare("R12", 12'h000);              // R12: outputs held at zero in reset
        rst_n = 1'b1;

        apply(0, 8'h7F, 8'h01, 0, "R1");      // R1: signed overflow, N set
        apply(0, 8'hFF, 8'h01, 0, "R1");      // R1: carry out, Z set
        apply(1, 8'h05, 8'h05, 0, "R2");      // R2: equal, no borrow, Z
        apply(1, 8'h03, 8'h05, 1, "R2");      // R2: borrow clears C
        apply(1, 8'h80, 8'h01, 0, "R2");      // R2: signed overflow
        apply(2, 8'hFE, 8'h01, 1, "R3");      // R3: add with carry wraps to zero
        apply(3, 8'h10, 8'h01, 0, "R3");      // R3: borrow in subtracts one more
        apply(3, 8'h10, 8'h01, 1, "R3");      // R3: no borrow in
        apply(4, 8'h00, 8'h80, 1, "R4");      // R4: move keeps C
        apply(5, 8'hAA, 8'hAA, 1, "R5");      // R5: xor to zero, Z and C kept
        apply(7, 8'hF0, 8'h3C, 0, "R5");
        apply(8, 8'h81, 8'h01, 0, "R6");      // R6: shift left, carry from bit 7
        apply(9, 8'h81, 8'h07, 0, "R6");      // R6: arithmetic right by 7
        apply(10, 8'h81, 8'h07, 0, "R6");     // R6: logical right by 7
        apply(11, 8'h81, 8'h03, 1, "R7");     // R7: rotate keeps C
        apply(15, 8'h80, 8'h01, 1, "R8");     // R8: carry enters bit 0
        apply(15, 8'h01, 8'h07, 1, "R8");     // R8: count 7
        apply(8, 8'h5A, 8'hF8, 1, "R9");      // R9: count 0, upper bits ignored
        apply(15, 8'h5A, 8'h08, 0, "R9");
        apply(10, 8'h5A, 8'h09, 1, "R9");     // R9: count 1 despite upper bits
        apply(12, 8'h10, 8'h10, 1, "R10");    // R10: low byte zero
        apply(13, 8'h10, 8'h10, 0, "R10");    // R10: unsigned high byte
        apply(14, 8'hFF, 8'hFF, 0, "R10");    // R10: (-1)*(-1) high byte 0
        apply(14, 8'h80, 8'h7F, 1, "R10");    // R10: negative product
        apply(13, 8'hFF, 8'hFF, 1, "R10");

        for (int k = 0; k < 4000; k++) begin
            int op;
            op = int'($urandom_range(15, 0));
            apply(op, int'($urandom_range(255, 0)), int'($urandom_range(255, 0)),
                  int'($urandom_range(1, 0)), tag_of(op));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R12: watchdog expired, actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule